// File: doc/BRIEF.md
# Paged Write Engine with Status Polling

This block is the device-side write path of a byte-wide paged nonvolatile memory. A host drives it through an SRAM-like strobe interface: active-low chip enable, output enable and write enable, with an address bus and a data bus. The block samples all three strobes on the system clock through a two-flop synchronizer. Each write strobe drops one byte into a page buffer and marks that byte as loaded. The upper address bits of the first byte pick the page. The low eight bits pick the slot within the page.

A byte-load window timer restarts with every accepted byte. When the window runs out with no new byte, loading closes and a program timer starts. When the program timer expires, the engine walks every slot of the buffer in ascending order. It sends only the marked bytes to the memory write port and then clears all the marks. Programming covers both the program timer and the commit walk. During programming, host reads return a status word instead of array data, and the host uses it to poll for completion. Outside programming, reads pass the array data through. Both timer lengths are parameters counted in clock cycles.

The controller is a four-state machine. The states are `ST_IDLE`, `ST_LOAD`, `ST_PROG` and `ST_COMMIT`, with these transitions:
- **first-byte**: from `ST_IDLE` to `ST_LOAD`, when the first byte is accepted.
- **reload**: `ST_LOAD` stays in `ST_LOAD` when a further byte is accepted, and the window restarts.
- **window-expired**: from `ST_LOAD` to `ST_PROG`.
- **program-expired**: from `ST_PROG` to `ST_COMMIT`.
- **walk-done**: from `ST_COMMIT` to `ST_IDLE`, once the last slot has been visited.

Top module: `pgwr_engine`

## Requirements
- R1: After reset, `busy`, `dout_en`, `mem_wr_en` and `dout` are all 0.
- R2: `dout_en` is 1 only while the synchronized chip enable and output enable are low and write enable is high; otherwise `dout` is 0. In `ST_IDLE` a read returns the array byte at `addr`.
- R3: A write is armed only while chip enable and write enable are both low and output enable is high. The address is taken when the second of the two strobes goes low. The data is taken when the first of them returns high. `busy` rises after the first accepted byte.
- R4: Bytes can be loaded in any order. Loading the same slot twice in one load phase keeps the last value.
- R5: The commit writes each loaded slot exactly once, in ascending slot order, to address {page, slot}. It writes no slot that was not loaded.
- R6: The page (address bits above bit 7) comes from the first byte of a load phase. Later bytes in the same phase use only their low 8 address bits.
- R7: Each accepted byte restarts a BLC_CYCLES window. If the window expires with no new byte, loading closes and programming begins.
- R8: The first commit write of slot 0 appears BLC_CYCLES + PROG_CYCLES clock cycles (within synchronizer latency) after the last byte's write strobe ends. `busy` falls when the commit ends.
- R9: A read during programming returns bit 7 of the last loaded byte inverted and bits 5..0 unchanged. After `busy` falls, reads return true array data.
- R10: During programming, bit 6 of the status word flips on each new read. The first read after loading closes shows 1.
- R11: Write strobes during programming are ignored: nothing is loaded and nothing extra is committed.
- R12: The loaded marks clear when a commit ends, so the next page commits only its own bytes.
- R13: A write strobe pulse made while output enable is low loads nothing and does not start a load phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Host address; page in upper bits, slot in low 8 |
| din | input | 8 | Host write data |
| dout | output | 8 | Read data or status word |
| dout_en | output | 1 | Output drive enable for `dout` (high impedance when 0) |
| busy | output | 1 | High from the first accepted byte until the commit ends |
| mem_rd_addr | output | ADDR_W | Array read address |
| mem_rd_data | input | 8 | Array read data, combinational from `mem_rd_addr` |
| mem_wr_en | output | 1 | Array write strobe, one byte per cycle |
| mem_wr_addr | output | ADDR_W | Array write address |
| mem_wr_data | output | 8 | Array write data |

## Verification
The in-line assertions check these rules on every cycle:
- The output drive rule, against the strobe levels two cycles earlier.
- Commit writes appear only while `busy` is high.
- The loaded marks stay frozen throughout `ST_PROG` and are empty when `busy` falls.
- The status bit 6 flips on each read start during programming.
- A timer's done pulse lasts exactly one cycle.

Only the bench scenarios show the rest:
- Which bytes land in the array, and in what order.
- That overwrites and page bits from later bytes are handled as required.
- The end-to-end timing from the last strobe to the first commit write.
- The exact status values seen by a polling host.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_PROG   = 2'd2,
        ST_COMMIT = 2'd3
    } eng_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/pgwr_strobe_sync.sv
module pgwr_strobe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_start,
    output logic wr_end,
    output logic rd_start,
    output logic rd_act
);

    logic [SYNC_STAGES-1:0] ce_sr, oe_sr, we_sr;
    logic s_ce, s_oe, s_we;
    logic wr_act, wr_act_q, rd_act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_sr    <= '1;
            oe_sr    <= '1;
            we_sr    <= '1;
            wr_act_q <= 1'b0;
            rd_act_q <= 1'b0;
        end else begin
            ce_sr    <= {ce_sr[SYNC_STAGES-2:0], ce_n};
            oe_sr    <= {oe_sr[SYNC_STAGES-2:0], oe_n};
            we_sr    <= {we_sr[SYNC_STAGES-2:0], we_n};
            wr_act_q <= wr_act;
            rd_act_q <= rd_act;
        end
    end

    always_comb begin
        s_ce     = ce_sr[SYNC_STAGES-1];
        s_oe     = oe_sr[SYNC_STAGES-1];
        s_we     = we_sr[SYNC_STAGES-1];
        // write armed only with output enable high
        wr_act   = !s_ce && !s_we && s_oe;
        rd_act   = !s_ce && !s_oe && s_we;
        wr_start = wr_act && !wr_act_q;
        wr_end   = !wr_act && wr_act_q;
        rd_start = rd_act && !rd_act_q;
    end

    // R3: a write ends only after it has started
    p_end_follows_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end |-> $past(wr_act));

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= '0;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == CW'(LEN - 1)) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb done = run && !start && (cnt == CW'(LEN - 1));

    // R7/R8: an expiry is a single-cycle event
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
    parameter int PAGE_BYTES = 256
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ld_en,
    input  logic [$clog2(PAGE_BYTES)-1:0]   ld_ofs,
    input  logic [7:0]                      ld_data,
    input  logic                            clr,
    input  logic [$clog2(PAGE_BYTES)-1:0]   rd_ofs,
    output logic [7:0]                      rd_data,
    output logic                            rd_valid,
    output logic [PAGE_BYTES-1:0]           vmask
);

    logic [7:0] slot [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;

    generate
        for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    valid_q[g] <= 1'b0;
                end else if (clr) begin
                    valid_q[g] <= 1'b0;
                end else if (ld_en && (ld_ofs == g[$clog2(PAGE_BYTES)-1:0])) begin
                    valid_q[g] <= 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (ld_en && (ld_ofs == g[$clog2(PAGE_BYTES)-1:0])) begin
                    slot[g] <= ld_data;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data  = slot[rd_ofs];
        rd_valid = valid_q[rd_ofs];
        vmask    = valid_q;
    end

    // R4: a loaded slot is marked on the following cycle
    p_load_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !clr) |=> valid_q[$past(ld_ofs)]);

endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine
    import pgwr_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int PAGE_BYTES  = 256,
    parameter int BLC_CYCLES  = 15000,
    parameter int PROG_CYCLES = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [7:0]        mem_wr_data
);

    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - OFS_W;

    eng_state_t state_q, state_d;

    logic              wr_start, wr_end, rd_start, rd_act;
    logic [ADDR_W-1:0] addr_lat;
    logic [PG_W-1:0]   page_q;
    logic [7:0]        last_q, buf_rd_data, dout_q;
    logic [OFS_W-1:0]  scan_idx;
    logic              tog_q, accept, polling, blc_done, prog_done;
    logic              scan_last, buf_rd_valid;
    logic [PAGE_BYTES-1:0] vmask;

    pgwr_strobe_sync #(.SYNC_STAGES(2)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .wr_start (wr_start),
        .wr_end   (wr_end),
        .rd_start (rd_start),
        .rd_act   (rd_act)
    );

    pgwr_timer #(.LEN(BLC_CYCLES)) i_blc_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .done  (blc_done)
    );

    pgwr_timer #(.LEN(PROG_CYCLES)) i_prog_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (blc_done),
        .done  (prog_done)
    );

    pgwr_page_buf #(.PAGE_BYTES(PAGE_BYTES)) i_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (accept),
        .ld_ofs   (addr_lat[OFS_W-1:0]),
        .ld_data  (din),
        .clr      (scan_last),
        .rd_ofs   (scan_idx),
        .rd_data  (buf_rd_data),
        .rd_valid (buf_rd_valid),
        .vmask    (vmask)
    );

    always_comb begin
        accept    = wr_end && ((state_q == ST_IDLE) || (state_q == ST_LOAD));
        polling   = (state_q == ST_PROG) || (state_q == ST_COMMIT);
        scan_last = (state_q == ST_COMMIT) && (scan_idx == OFS_W'(PAGE_BYTES - 1));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)    state_d = ST_LOAD;
            ST_LOAD:   if (blc_done)  state_d = ST_PROG;
            ST_PROG:   if (prog_done) state_d = ST_COMMIT;
            ST_COMMIT: if (scan_last) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_lat <= '0;
            page_q   <= '0;
            last_q   <= '0;
            scan_idx <= '0;
            tog_q    <= 1'b0;
            dout_q   <= '0;
        end else begin
            if (wr_start) addr_lat <= addr;
            if (accept && (state_q == ST_IDLE)) page_q <= addr_lat[ADDR_W-1:OFS_W];
            if (accept) last_q <= din;
            if (state_q == ST_COMMIT) scan_idx <= scan_idx + 1'b1;
            else                      scan_idx <= '0;
            if (blc_done)                tog_q <= 1'b0;
            else if (polling && rd_start) tog_q <= ~tog_q;
            if (!rd_act)      dout_q <= '0;
            else if (polling) dout_q <= {~last_q[7], tog_q, last_q[5:0]};
            else              dout_q <= mem_rd_data;
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        mem_wr_en   = (state_q == ST_COMMIT) && buf_rd_valid;
        mem_wr_addr = {page_q, scan_idx};
        mem_wr_data = buf_rd_data;
        mem_rd_addr = addr;
        dout        = dout_q;
        dout_en     = rd_act;
    end

    // R2: drive only when the strobes two cycles back formed a read
    p_drive_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!$past(ce_n, 2) && !$past(oe_n, 2) && $past(we_n, 2)));

    // R3: busy starts only from an ended write strobe
    p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_end));

    // R5: array writes occur only inside a busy period
    p_wr_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> busy);

    // R11: marks cannot change while the program timer runs
    p_frozen_in_prog_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG) |=> $stable(vmask));

    // R12: no marks remain once busy drops
    p_mask_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($countones(vmask) == 0));

    // R10: each poll start flips the status toggle
    p_toggle_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (polling && rd_start) |=> (tog_q != $past(tog_q)));

endmodule

// File: tb/test_pgwr_engine.sv
module test_pgwr_engine;

    localparam int AW   = 12;
    localparam int BLC  = 40;
    localparam int PROG = 300;
    localparam int MSZ  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en, busy, mem_wr_en;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]    mem_rd_data, mem_wr_data;

    logic [7:0] arr  [MSZ];
    logic [7:0] expv [MSZ];
    int vectors = 0, miscompares = 0;
    int wr_count = 0, order_err = 0;
    logic [AW-1:0] prev_wa;
    logic have_prev = 1'b0;
    logic [255:0] loaded;

    always #2.5 clk = ~clk;

    pgwr_engine #(.ADDR_W(AW), .PAGE_BYTES(256), .BLC_CYCLES(BLC), .PROG_CYCLES(PROG)) i_pgwr_engine (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    assign mem_rd_data = arr[mem_rd_addr];

    // array model and commit monitor, sampled away from the rising edge
    always @(negedge clk) begin
        if (mem_wr_en) begin
            arr[mem_wr_addr] = mem_wr_data;
            wr_count++;
            if (have_prev && mem_wr_addr <= prev_wa) order_err++;
            prev_wa   = mem_wr_addr;
            have_prev = 1'b1;
        end
    end

    function automatic logic [7:0] poll_word(input logic [7:0] last, input logic tg);
        return {~last[7], tg, last[5:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        vectors++;
        if (act !== exp_v) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic clr_mon();
        wr_count  = 0;
        order_err = 0;
        have_prev = 1'b0;
    endtask

    task automatic wr_byte(input logic [AW-1:0] a, input logic [7:0] d, input logic oe_lvl);
        @(negedge clk); addr = a; din = d; oe_n = oe_lvl; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        repeat (3) @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
        @(negedge clk); addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        repeat (6) @(negedge clk);
        d = dout; en = dout_en;
        oe_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic en;
        logic [AW-1:0] a;
        int n, cnt, mism;
        logic [3:0] pg;

        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < MSZ; i++) begin
            arr[i]  = 8'(i * 37 + 11);
            expv[i] = arr[i];
        end
        repeat (4) @(negedge clk);

        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 dout_en", dout_en, 0);
        chk("R1 mem_wr_en", mem_wr_en, 0);
        chk("R1 dout", dout, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: idle reads pass the array through
        for (int k = 0; k < 3; k++) begin
            a = AW'($urandom % MSZ);
            rd(a, d, en);
            chk("R2 read enable", en, 1);
            chk("R2 read data", d, expv[a]);
        end
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 oe high no drive", dout_en, 0);
        chk("R2 oe high dout", dout, 0);
        ce_n = 1'b1;

        // R3 R4 R9 R10 R11: directed page 3, any order, overwrite, boundaries
        clr_mon();
        wr_byte({4'd3, 8'd5}, 8'h9A, 1'b1);
        chk("R3 busy after first byte", busy, 1);
        wr_byte({4'd3, 8'd3}, 8'h21, 1'b1);
        wr_byte({4'd3, 8'd200}, 8'hE7, 1'b1);
        wr_byte({4'd3, 8'd3}, 8'h66, 1'b1);
        wr_byte({4'd3, 8'd255}, 8'h80, 1'b1);
        wr_byte({4'd3, 8'd0}, 8'h4C, 1'b1);
        expv[{4'd3, 8'd5}]   = 8'h9A;
        expv[{4'd3, 8'd3}]   = 8'h66;
        expv[{4'd3, 8'd200}] = 8'hE7;
        expv[{4'd3, 8'd255}] = 8'h80;
        expv[{4'd3, 8'd0}]   = 8'h4C;
        repeat (BLC + 8) @(negedge clk);
        rd({4'd3, 8'd0}, d, en);
        chk("R9 poll bit7 inverted, R10 first toggle", d, poll_word(8'h4C, 1'b1));
        rd({4'd3, 8'd0}, d, en);
        chk("R10 second poll toggles", d, poll_word(8'h4C, 1'b0));
        rd({4'd3, 8'd9}, d, en);
        chk("R10 third poll toggles", d, poll_word(8'h4C, 1'b1));
        wr_byte({4'd3, 8'd77}, 8'h11, 1'b1);   // R11: ignored while programming
        wait_idle();
        chk("R5 write count", wr_count, 5);
        chk("R5 ascending order", order_err, 0);
        chk("R4 overwrite kept last", arr[{4'd3, 8'd3}], 8'h66);
        chk("R5 slot 255 boundary", arr[{4'd3, 8'd255}], 8'h80);
        chk("R11 ignored slot untouched", arr[{4'd3, 8'd77}], expv[{4'd3, 8'd77}]);
        rd({4'd3, 8'd0}, d, en);
        chk("R9 true data after busy", d, 8'h4C);
        chk("R8 busy low after commit", busy, 0);

        // R6 R12: page from first byte only; only this page's bytes commit
        clr_mon();
        wr_byte({4'd2, 8'd1}, 8'h5A, 1'b1);
        wr_byte({4'd7, 8'd10}, 8'hC3, 1'b1);
        expv[{4'd2, 8'd1}]  = 8'h5A;
        expv[{4'd2, 8'd10}] = 8'hC3;
        wait_idle();
        chk("R6 later byte goes to first page", arr[{4'd2, 8'd10}], 8'hC3);
        chk("R6 other page untouched", arr[{4'd7, 8'd10}], expv[{4'd7, 8'd10}]);
        chk("R12 only new bytes committed", wr_count, 2);

        // R13: strobe with output enable low does nothing
        clr_mon();
        wr_byte({4'd5, 8'd6}, 8'h33, 1'b0);
        repeat (BLC + 10) @(negedge clk);
        chk("R13 no busy", busy, 0);
        chk("R13 no commit", wr_count, 0);
        rd({4'd5, 8'd6}, d, en);
        chk("R13 array unchanged", d, expv[{4'd5, 8'd6}]);

        // R7 R8: window expiry closes loading; commit timing
        clr_mon();
        wr_byte({4'd4, 8'd0}, 8'hA5, 1'b1);
        expv[{4'd4, 8'd0}] = 8'hA5;
        n = 0;
        while (!mem_wr_en && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R8 commit delay in range", (n >= BLC + PROG - 4) && (n <= BLC + PROG), 1);
        wait_idle();
        clr_mon();
        wr_byte({4'd6, 8'd1}, 8'h12, 1'b1);
        expv[{4'd6, 8'd1}] = 8'h12;
        repeat (BLC + 10) @(negedge clk);
        wr_byte({4'd6, 8'd2}, 8'h34, 1'b1);   // after window: too late
        wait_idle();
        chk("R7 one byte committed", wr_count, 1);
        chk("R7 late byte dropped", arr[{4'd6, 8'd2}], expv[{4'd6, 8'd2}]);

        // random pages
        for (int p = 0; p < 6; p++) begin
            clr_mon();
            loaded = '0;
            pg = 4'($urandom % 16);
            cnt = 1 + ($urandom % 24);
            for (int k = 0; k < cnt; k++) begin
                logic [7:0] o, v;
                o = 8'($urandom);
                v = 8'($urandom);
                wr_byte({pg, o}, v, 1'b1);
                expv[{pg, o}] = v;
                loaded[o] = 1'b1;
            end
            wait_idle();
            chk("R5 random write count", wr_count, $countones(loaded));
            chk("R5 random order", order_err, 0);
            mism = 0;
            for (int s = 0; s < 256; s++) if (arr[{pg, 8'(s)}] !== expv[{pg, 8'(s)}]) mism++;
            chk("R4 random page contents", mism, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule